// File: doc/BRIEF.md
# I2C Slave Receive Engine with Flag-Gated Acknowledge

This block is the target side of a two-wire serial bus, clocked by the chip's system clock. Both bus lines are brought in through synchronizers and a minimum-pulse filter. The block finds START and STOP conditions and shifts in the first byte after a START. It compares the upper seven bits of that byte with a programmable own address. On a hit it either keeps taking bytes (write direction) or shifts out a preloaded byte (read direction). It acknowledges by driving an open-drain pull-down request on the data line.

Every byte that completes after a matched address raises an interrupt flag. The byte is copied into a one-byte receive buffer and acknowledged only when the buffer is empty and no overflow is pending. If the buffer is still full, the new byte is refused with a NACK and the overflow flag is set. The overflow flag stays set until a clear strobe arrives from software. Reading the buffer empties it.

Top module: `i2cs_slave_rx`

## Requirements
- R1: After a START, a first byte whose bits 7..1 equal `own_addr_i` is acknowledged (`sda_pull_o`=1 through the ninth SCL clock) if buffer-full and overflow are both clear. The full byte, including direction bit 0, is copied to `rx_byte_o` and `buf_full_o` is set.
- R2: In the write direction (bit 0 of the address byte = 0), each later data byte is acknowledged and loaded into the buffer when both flags are clear.
- R3: A byte that completes while `buf_full_o`=1 gets no acknowledge, leaves `rx_byte_o` unchanged and sets `overflow_o`.
- R4: A byte that completes while `overflow_o`=1 gets no acknowledge and leaves `rx_byte_o` unchanged, even if `buf_full_o`=0.
- R5: `irq_o` is set at the end of every byte after a matched address, in all four buffer-full/overflow combinations. It clears only on a `clr_if_i` pulse.
- R6: A `rd_buf_i` pulse clears `buf_full_o`.
- R7: `overflow_o` survives buffer reads, later bytes and STOP. It clears only on a `clr_ov_i` pulse.
- R8: An address byte that does not match gets no acknowledge and raises no flag. Bytes that follow it are ignored until the next START.
- R9: With direction bit 1 on a matched address, the block drives `tx_byte_i` MSB first, pulling SDA for each 0 bit. It releases SDA for the master's acknowledge and sends `tx_byte_i` again after a master ACK. After a master NACK it goes idle with SDA released.
- R10: SCL pulses shorter than `FILT_CYC` system clocks are ignored and do not shift a bit.
- R11: A STOP (SDA rising while SCL high) returns the block to idle, so bytes without a new START are ignored. A repeated START (SDA falling while SCL high) makes the next byte an address byte again.
- R12: After reset all flags are 0 and `sda_pull_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (wired level) |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| own_addr_i | input | DATA_W-1 | Programmable own address |
| tx_byte_i | input | DATA_W | Byte sent in the read direction |
| rd_buf_i | input | 1 | Buffer read strobe, clears buffer-full |
| clr_ov_i | input | 1 | Overflow clear strobe |
| clr_if_i | input | 1 | Interrupt flag clear strobe |
| rx_byte_o | output | DATA_W | Receive buffer |
| buf_full_o | output | 1 | Buffer-full flag |
| overflow_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt flag |

## Verification
The bench walks through all four buffer-full/overflow combinations at the end of a byte. A design that ignored overflow would acknowledge and overwrite the buffer after a read. A design that raised the interrupt only on accepted bytes would stay silent on refused ones. It checks that overflow survives reads and STOP, which catches a flag that clears itself. It sends a mismatched address, bytes after a STOP, and a repeated START, which expose an engine that goes on decoding data when it should be idle. Short SCL glitches placed inside data bits would corrupt the received value if the filter let them through.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } slv_state_e;
endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
   parameter int   SYNC_STAGES = 2,
   parameter int   FILT_CYC    = 4,
   parameter logic RST_VAL     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic clean_o
);
   localparam int CW = $clog2(FILT_CYC + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_CYC < 1) begin : g_bad_filt
      $error("FILT_CYC must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic [CW-1:0]          cnt_q;
   logic                   out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{RST_VAL}};
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   // A new level is taken only after FILT_CYC consecutive disagreeing cycles.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         out_q <= RST_VAL;
      end else if (synced == out_q) begin
         cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYC - 1)) begin
         out_q <= synced;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
   assign clean_o = out_q;

   assert_glitch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (synced != out_q && cnt_q != CW'(FILT_CYC - 1)) |=> $stable(out_q));
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_i;
         sda_d <= sda_i;
      end
   end

   assign scl_rise_o = scl_i & ~scl_d;
   assign scl_fall_o = ~scl_i & scl_d;
   assign start_o    = scl_i & scl_d & sda_d & ~sda_i;
   assign stop_o     = scl_i & scl_d & ~sda_d & sda_i;
endmodule

// File: rtl/i2cs_rx_flags.sv
module i2cs_rx_flags #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_done_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              rd_i,
   input  logic              clr_ov_i,
   input  logic              clr_if_i,
   output logic [DATA_W-1:0] buf_o,
   output logic              bf_o,
   output logic              ov_o,
   output logic              if_o,
   output logic              accept_o
);
   logic [DATA_W-1:0] buf_q;
   logic              bf_q, ov_q, if_q;
   logic              take;

   assign accept_o = ~bf_q & ~ov_q;
   assign take     = byte_done_i & accept_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         bf_q  <= 1'b0;
         ov_q  <= 1'b0;
         if_q  <= 1'b0;
      end else begin
         if (take) buf_q <= byte_i;

         if (take)      bf_q <= 1'b1;
         else if (rd_i) bf_q <= 1'b0;

         if (byte_done_i && bf_q) ov_q <= 1'b1;
         else if (clr_ov_i)       ov_q <= 1'b0;

         if (byte_done_i)   if_q <= 1'b1;
         else if (clr_if_i) if_q <= 1'b0;
      end
   end

   assign buf_o = buf_q;
   assign bf_o  = bf_q;
   assign ov_o  = ov_q;
   assign if_o  = if_q;

   assert_full_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done_i && bf_q) |=> (ov_q && $stable(buf_q)));
   assert_ov_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done_i && ov_q) |=> $stable(buf_q));
   assert_irq_every_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done_i |=> if_q);
   assert_read_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !byte_done_i) |=> !bf_q);
   assert_ov_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_q && !clr_ov_i) |=> ov_q);
endmodule

// File: rtl/i2cs_slave_rx.sv
module i2cs_slave_rx
   import i2cs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int FILT_CYC    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   input  logic [DATA_W-2:0] own_addr_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   input  logic              rd_buf_i,
   input  logic              clr_ov_i,
   input  logic              clr_if_i,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              buf_full_o,
   output logic              overflow_o,
   output logic              irq_o
);
   localparam int CNT_W   = $clog2(DATA_W + 1);
   localparam int N_LINES = 2;

   if (DATA_W < 4) begin : g_bad_width
      $error("DATA_W must be at least 4");
   end

   // Line conditioning: index 0 = clock line, 1 = data line
   logic [N_LINES-1:0] raw_lines, clean_lines;
   assign raw_lines = {sda_i, scl_i};

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      i2cs_line_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_CYC   (FILT_CYC),
         .RST_VAL    (1'b1)
      ) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (raw_lines[g]),
         .clean_o(clean_lines[g])
      );
   end

   logic scl_c, sda_c;
   assign scl_c = clean_lines[0];
   assign sda_c = clean_lines[1];

   logic scl_rise, scl_fall, bus_start, bus_stop;

   i2cs_bus_events u_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_c),
      .sda_i     (sda_c),
      .scl_rise_o(scl_rise),
      .scl_fall_o(scl_fall),
      .start_o   (bus_start),
      .stop_o    (bus_stop)
   );

   slv_state_e        state_q;
   logic [DATA_W-1:0] sh_q, tx_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              oe_q, rw_q, acked_q, mack_q;
   logic              addr_hit, byte_end, byte_done, accept;

   assign addr_hit  = (sh_q[DATA_W-1:1] == own_addr_i);
   assign byte_end  = scl_fall && (cnt_q == CNT_W'(DATA_W));
   assign byte_done = byte_end &&
                      ((state_q == ST_ADDR && addr_hit) || state_q == ST_RX);

   i2cs_rx_flags #(.DATA_W(DATA_W)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_done_i(byte_done),
      .byte_i     (sh_q),
      .rd_i       (rd_buf_i),
      .clr_ov_i   (clr_ov_i),
      .clr_if_i   (clr_if_i),
      .buf_o      (rx_byte_o),
      .bf_o       (buf_full_o),
      .ov_o       (overflow_o),
      .if_o       (irq_o),
      .accept_o   (accept)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sh_q    <= '0;
         tx_q    <= '0;
         cnt_q   <= '0;
         oe_q    <= 1'b0;
         rw_q    <= 1'b0;
         acked_q <= 1'b0;
         mack_q  <= 1'b0;
      end else if (bus_start) begin
         state_q <= ST_ADDR;
         cnt_q   <= '0;
         oe_q    <= 1'b0;
      end else if (bus_stop) begin
         state_q <= ST_IDLE;
         oe_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_ADDR, ST_RX: begin
               if (scl_rise && cnt_q < CNT_W'(DATA_W)) begin
                  sh_q  <= {sh_q[DATA_W-2:0], sda_c};
                  cnt_q <= cnt_q + 1'b1;
               end else if (byte_end) begin
                  cnt_q <= '0;
                  if (state_q == ST_ADDR && !addr_hit) begin
                     state_q <= ST_IDLE;
                  end else begin
                     oe_q    <= accept;
                     acked_q <= accept;
                     if (state_q == ST_ADDR) begin
                        rw_q    <= sh_q[0];
                        state_q <= ST_ADDR_ACK;
                     end else begin
                        state_q <= ST_RX_ACK;
                     end
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  if (!acked_q) begin
                     state_q <= ST_IDLE;
                     oe_q    <= 1'b0;
                  end else if (rw_q) begin
                     state_q <= ST_TX;
                     oe_q    <= ~tx_byte_i[DATA_W-1];
                     tx_q    <= tx_byte_i << 1;
                     cnt_q   <= CNT_W'(1);
                  end else begin
                     state_q <= ST_RX;
                     oe_q    <= 1'b0;
                  end
               end
            end
            ST_RX_ACK: begin
               if (scl_fall) begin
                  oe_q    <= 1'b0;
                  state_q <= ST_RX;
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (cnt_q == CNT_W'(DATA_W)) begin
                     oe_q    <= 1'b0;
                     state_q <= ST_TX_ACK;
                  end else begin
                     oe_q  <= ~tx_q[DATA_W-1];
                     tx_q  <= tx_q << 1;
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) begin
                  mack_q <= ~sda_c;
               end else if (scl_fall) begin
                  if (mack_q) begin
                     state_q <= ST_TX;
                     oe_q    <= ~tx_byte_i[DATA_W-1];
                     tx_q    <= tx_byte_i << 1;
                     cnt_q   <= CNT_W'(1);
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sda_pull_o = oe_q;

   assert_ack_on_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && accept && !bus_start && !bus_stop) |=> sda_pull_o);
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !sda_pull_o);
   assert_release_for_master_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TX_ACK) |-> !sda_pull_o);
   assert_stop_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stop && !bus_start) |=> (state_q == ST_IDLE));
endmodule

// File: tb/tb_i2cs_slave_rx.sv
module tb_i2cs_slave_rx;
   localparam logic [6:0] OWN = 7'h2A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       sda_pull;
   logic       sda_bus;
   logic [7:0] tx_byte = 8'hC3;
   logic       rd_buf = 1'b0, clr_ov = 1'b0, clr_if = 1'b0;
   logic [7:0] rx_byte;
   logic       buf_full, overflow, irq;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_pull;

   i2cs_slave_rx dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_pull_o(sda_pull), .own_addr_i(OWN), .tx_byte_i(tx_byte),
      .rd_buf_i(rd_buf), .clr_ov_i(clr_ov), .clr_if_i(clr_if),
      .rx_byte_o(rx_byte), .buf_full_o(buf_full), .overflow_o(overflow),
      .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wcyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_rd();  @(negedge clk) rd_buf = 1; @(negedge clk) rd_buf = 0; wcyc(2); endtask
   task automatic pulse_if();  @(negedge clk) clr_if = 1; @(negedge clk) clr_if = 0; wcyc(2); endtask
   task automatic pulse_ov();  @(negedge clk) clr_ov = 1; @(negedge clk) clr_ov = 0; wcyc(2); endtask

   task automatic bus_start();
      scl_m = 0; wcyc(10); sda_m = 1; wcyc(10);
      scl_m = 1; wcyc(20); sda_m = 0; wcyc(20); scl_m = 0;
   endtask

   task automatic bus_stop();
      scl_m = 0; wcyc(10); sda_m = 0; wcyc(10);
      scl_m = 1; wcyc(20); sda_m = 1; wcyc(20);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         scl_m = 0; wcyc(10); sda_m = b[i];
         if (glitch) begin
            wcyc(3); scl_m = 1; wcyc(2); scl_m = 0; wcyc(5);
         end else begin
            wcyc(10);
         end
         scl_m = 1; wcyc(20);
      end
      scl_m = 0; wcyc(10); sda_m = 1; wcyc(10);
      scl_m = 1; wcyc(10); ack = ~sda_bus; wcyc(10);
      scl_m = 0; wcyc(5);
   endtask

   task automatic read_byte(input bit mack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         scl_m = 0; sda_m = 1; wcyc(20);
         scl_m = 1; wcyc(10); b[i] = sda_bus; wcyc(10);
      end
      scl_m = 0; wcyc(10); sda_m = ~mack; wcyc(10);
      scl_m = 1; wcyc(20); scl_m = 0; wcyc(10); sda_m = 1;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin : stim
      bit ack;
      logic [7:0] rb;
      wcyc(5); rst_n = 1; wcyc(5);

      // R12 reset state
      chk("R12 buf_full", buf_full, 0);
      chk("R12 overflow", overflow, 0);
      chk("R12 irq", irq, 0);
      chk("R12 sda_pull", sda_pull, 0);

      // R1 matched write address
      bus_start();
      send_byte({OWN, 1'b0}, 0, ack);
      chk("R1 ack", ack, 1);
      chk("R1 rx_byte", rx_byte, {OWN, 1'b0});
      chk("R1 buf_full", buf_full, 1);
      chk("R5 irq on address", irq, 1);
      pulse_rd();
      chk("R6 buf_full cleared", buf_full, 0);
      pulse_if();
      chk("R5 irq cleared", irq, 0);

      // R2 sweep of data values, flags clear each time
      for (int i = 0; i < 16; i++) begin
         logic [7:0] v;
         v = 8'((i * 37 + 5) ^ (i << 4));
         send_byte(v, 0, ack);
         chk("R2 ack", ack, 1);
         chk("R2 rx_byte", rx_byte, v);
         chk("R2 buf_full", buf_full, 1);
         pulse_rd(); pulse_if();
      end

      // R10 glitches inside each bit period
      send_byte(8'h6B, 1, ack);
      chk("R10 ack", ack, 1);
      chk("R10 rx_byte", rx_byte, 8'h6B);
      pulse_if();

      // R3 buffer still full (0x6B unread)
      send_byte(8'h22, 0, ack);
      chk("R3 nack", ack, 0);
      chk("R3 rx_byte kept", rx_byte, 8'h6B);
      chk("R3 overflow set", overflow, 1);
      chk("R5 irq on refused byte", irq, 1);
      pulse_if();

      // both flags set
      send_byte(8'h44, 0, ack);
      chk("R3 nack both set", ack, 0);
      chk("R3 rx_byte kept both set", rx_byte, 8'h6B);
      chk("R5 irq both set", irq, 1);
      pulse_if();

      // R4 overflow only
      pulse_rd();
      chk("R6 buf_full cleared", buf_full, 0);
      chk("R7 overflow survives read", overflow, 1);
      send_byte(8'h33, 0, ack);
      chk("R4 nack", ack, 0);
      chk("R4 rx_byte kept", rx_byte, 8'h6B);
      chk("R4 buf_full stays clear", buf_full, 0);
      chk("R5 irq overflow only", irq, 1);
      pulse_if();
      bus_stop();
      chk("R7 overflow survives stop", overflow, 1);
      pulse_ov();
      chk("R7 overflow cleared", overflow, 0);

      // R8 mismatched address
      bus_start();
      send_byte({OWN + 7'd1, 1'b0}, 0, ack);
      chk("R8 nack address", ack, 0);
      chk("R8 irq", irq, 0);
      send_byte(8'h77, 0, ack);
      chk("R8 data ignored", ack, 0);
      chk("R8 irq after data", irq, 0);
      chk("R8 buf_full", buf_full, 0);
      bus_stop();

      // R9 read direction
      bus_start();
      send_byte({OWN, 1'b1}, 0, ack);
      chk("R9 ack read address", ack, 1);
      chk("R9 rx_byte", rx_byte, {OWN, 1'b1});
      pulse_rd(); pulse_if();
      read_byte(1, rb);
      chk("R9 first byte", rb, tx_byte);
      read_byte(0, rb);
      chk("R9 repeat byte", rb, tx_byte);
      wcyc(15);
      chk("R9 released after nack", sda_pull, 0);
      bus_stop();

      // R11 repeated start and stop
      bus_start();
      send_byte({OWN, 1'b0}, 0, ack);
      pulse_rd(); pulse_if();
      send_byte(8'h12, 0, ack);
      chk("R11 data before restart", ack, 1);
      pulse_rd(); pulse_if();
      bus_start();
      send_byte({OWN + 7'd1, 1'b0}, 0, ack);
      chk("R11 restart decodes address", ack, 0);
      bus_start();
      send_byte({OWN, 1'b0}, 0, ack);
      chk("R11 restart matches", ack, 1);
      pulse_rd(); pulse_if();
      bus_stop();
      send_byte(8'h99, 0, ack);
      chk("R11 ignored after stop", ack, 0);
      chk("R11 irq after stop", irq, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule